// File: doc/BRIEF.md
# Encoded-Product Column Accumulator

This block is the summing end of one column in a multiply-accumulate array whose multipliers do not produce ordinary binary products. Each multiplier emits a wide code word in which every bit stands for a signed amount. That amount is set for each bit position and need not be a power of two. The block takes the code words of all lanes of the column on each input beat. For each bit position it counts how many lanes have that bit set, and it keeps adding these counts over consecutive beats.

When the final beat of an accumulation arrives, the block converts its per-position counts into one ordinary two's-complement number. It multiplies each count by the signed weight of its position and adds the results. This conversion happens only once, after all counting is done. The result is registered and flagged for one cycle, ready for a conventional binary accumulation stage. The position weights sit in a small register file that is loaded through a write port, one entry per write.

A clear input discards a running accumulation. After a final beat, the counters start the next accumulation from zero without any extra command.

Top module: `enc_column_sum`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `out_sum` is 0 and every position weight is 0, so an accumulation decoded before any weight write yields 0.
- R2: Lane i of a beat occupies `in_vec[i*ENC_BITS +: ENC_BITS]`, and bit j of that slice belongs to position j. On a beat with `in_valid`=1, the count of position j grows by the number of lanes whose bit j is 1.
- R3: Counts keep growing across up to MAX_BEATS beats of one accumulation without wrapping. With every lane all-ones for MAX_BEATS beats, the decoded sum equals N_LANES*MAX_BEATS times the sum of the weights, including when all weights are -32768 or all are 32767.
- R4: The decoded value is the exact signed sum over positions of count times weight, where the weights are 16-bit two's-complement. It equals the sum, over every set bit of every lane of every beat, of that bit's position weight.
- R5: `out_valid` is 1 for exactly the one cycle that follows the clock edge at which `in_valid` and `in_last` are both 1. `out_sum` changes only at that edge and holds its value in between.
- R6: The beat after a final beat starts a new accumulation from zero counts, even when the two beats are back to back.
- R7: While `in_clear` is 1, the running counts are dropped. A beat presented in the same cycle as `in_clear` becomes the first beat of a new accumulation.
- R8: Cycles with `in_valid`=0 and `in_clear`=0 leave the running counts unchanged, so idle gaps between beats do not alter the result.
- R9: A cycle with `wt_we`=1 stores `wt_data` as the weight of position `wt_addr`. Decodes from the next clock edge on use the new weight, and the other positions keep their weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present on `in_vec` |
| in_last | input | 1 | This beat closes the accumulation |
| in_clear | input | 1 | Drop running counts |
| in_vec | input | N_LANES*ENC_BITS | Code words of all lanes |
| wt_we | input | 1 | Weight write strobe |
| wt_addr | input | max(1,clog2(ENC_BITS)) | Position being written |
| wt_data | input | 16 | Signed weight value |
| out_valid | output | 1 | Decoded sum valid (one cycle) |
| out_sum | output | SUM_W | Signed decoded partial sum |

## Verification
On every cycle, the assertions watch the counter bank, the weight file and the output register. They check that counts never shrink within an accumulation and that they sit still across idle cycles. They also check that counts are zero after a final beat or a lone clear, that a written weight lands in its entry, and that the output flag pulses once while the sum holds in between. Only the bench scenarios can show that the decoded numbers are right. The bench compares them against a model that adds position weights bit by bit over the raw code words. Those scenarios cover negative and extreme weights, full-length all-ones runs, idle gaps, clears and back-to-back accumulations.

// File: rtl/enc_col_pkg.sv
package enc_col_pkg;
  localparam int unsigned WT_W = 16;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned addr_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/enc_lane_popcount.sv
module enc_lane_popcount #(
  parameter int unsigned N_LANES  = 8,
  parameter int unsigned ENC_BITS = 16,
  parameter int unsigned PC_W     = 4
) (
  input  logic [N_LANES*ENC_BITS-1:0]  lanes,
  output logic [ENC_BITS-1:0][PC_W-1:0] pos_cnt
);
  for (genvar j = 0; j < ENC_BITS; j++) begin : g_pos
    always_comb begin
      pos_cnt[j] = '0;
      for (int i = 0; i < N_LANES; i++) begin
        pos_cnt[j] = pos_cnt[j] + PC_W'(lanes[i*ENC_BITS + j]);
      end
    end
  end
endmodule

// File: rtl/enc_pos_counters.sv
module enc_pos_counters #(
  parameter int unsigned ENC_BITS = 16,
  parameter int unsigned PC_W     = 4,
  parameter int unsigned ACC_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           beat,
  input  logic                           last,
  input  logic                           clear,
  input  logic [ENC_BITS-1:0][PC_W-1:0]  pos_cnt,
  output logic [ENC_BITS-1:0][ACC_W-1:0] cnt_next
);
  logic [ENC_BITS-1:0][ACC_W-1:0] cnt_q;

  for (genvar j = 0; j < ENC_BITS; j++) begin : g_ctr
    logic [ACC_W-1:0] base;
    always_comb begin
      base        = clear ? '0 : cnt_q[j];
      cnt_next[j] = beat ? base + ACC_W'(pos_cnt[j]) : base;
    end

    always_ff @(posedge clk) begin
      if (rst)               cnt_q[j] <= '0;
      else if (beat && last) cnt_q[j] <= '0;
      else                   cnt_q[j] <= cnt_next[j];
    end

    // R3: within one accumulation a count only grows
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      (beat && !clear && !last) |=> (cnt_q[j] >= $past(cnt_q[j])));
    // R8: idle cycles keep the count
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!beat && !clear) |=> $stable(cnt_q[j]));
    // R6: after a final beat the count restarts at zero
    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
      (beat && last) |=> (cnt_q[j] == '0));
    // R7: a lone clear empties the count
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (clear && !beat) |=> (cnt_q[j] == '0));
  end
endmodule

// File: rtl/enc_weight_file.sv
module enc_weight_file #(
  parameter int unsigned ENC_BITS = 16,
  parameter int unsigned WT_W     = 16,
  parameter int unsigned AW       = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [WT_W-1:0]               data,
  output logic [ENC_BITS-1:0][WT_W-1:0] weights
);
  logic [WT_W-1:0] mem [ENC_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ENC_BITS; k++) mem[k] <= '0;
    end else if (we && (32'(addr) < ENC_BITS)) begin
      mem[addr] <= data;
    end
  end

  always_comb begin
    for (int k = 0; k < ENC_BITS; k++) weights[k] = mem[k];
  end

  // R9: a write lands in the addressed entry
  assert_wt_write_R9: assert property (@(posedge clk) disable iff (rst)
    (we && (32'(addr) < ENC_BITS)) |=> (mem[$past(addr)] == $past(data)));
endmodule

// File: rtl/enc_weight_decoder.sv
module enc_weight_decoder #(
  parameter int unsigned ENC_BITS = 16,
  parameter int unsigned WT_W     = 16,
  parameter int unsigned ACC_W    = 8,
  parameter int unsigned SUM_W    = 29
) (
  input  logic [ENC_BITS-1:0][ACC_W-1:0] counts,
  input  logic [ENC_BITS-1:0][WT_W-1:0]  weights,
  output logic signed [SUM_W-1:0]        sum
);
  logic signed [SUM_W-1:0] term [ENC_BITS];

  for (genvar j = 0; j < ENC_BITS; j++) begin : g_term
    logic signed [SUM_W-1:0] w_ext;
    logic signed [SUM_W-1:0] c_ext;
    always_comb begin
      w_ext   = {{(SUM_W-WT_W){weights[j][WT_W-1]}}, weights[j]};
      c_ext   = {{(SUM_W-ACC_W){1'b0}}, counts[j]};
      term[j] = w_ext * c_ext;
    end
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < ENC_BITS; j++) sum = sum + term[j];
  end
endmodule

// File: rtl/enc_column_sum.sv
module enc_column_sum
  import enc_col_pkg::*;
#(
  parameter int unsigned N_LANES   = 8,
  parameter int unsigned ENC_BITS  = 16,
  parameter int unsigned MAX_BEATS = 16,
  localparam int unsigned PC_W     = bits_for(N_LANES),
  localparam int unsigned ACC_W    = bits_for(N_LANES * MAX_BEATS),
  localparam int unsigned AW       = addr_bits(ENC_BITS),
  localparam int unsigned SUM_W    = WT_W + ACC_W + 1 + $clog2(ENC_BITS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_last,
  input  logic                        in_clear,
  input  logic [N_LANES*ENC_BITS-1:0] in_vec,
  input  logic                        wt_we,
  input  logic [AW-1:0]               wt_addr,
  input  logic [WT_W-1:0]             wt_data,
  output logic                        out_valid,
  output logic [SUM_W-1:0]            out_sum
);
  logic [ENC_BITS-1:0][PC_W-1:0]  pos_cnt;
  logic [ENC_BITS-1:0][ACC_W-1:0] cnt_next;
  logic [ENC_BITS-1:0][WT_W-1:0]  weights;
  logic signed [SUM_W-1:0]        dec_sum;
  logic                           close_acc;

  assign close_acc = in_valid && in_last;

  enc_lane_popcount #(.N_LANES(N_LANES), .ENC_BITS(ENC_BITS), .PC_W(PC_W)) u_pop (
    .lanes(in_vec), .pos_cnt(pos_cnt));

  enc_pos_counters #(.ENC_BITS(ENC_BITS), .PC_W(PC_W), .ACC_W(ACC_W)) u_ctr (
    .clk(clk), .rst(rst), .beat(in_valid), .last(in_last), .clear(in_clear),
    .pos_cnt(pos_cnt), .cnt_next(cnt_next));

  enc_weight_file #(.ENC_BITS(ENC_BITS), .WT_W(WT_W), .AW(AW)) u_wt (
    .clk(clk), .rst(rst), .we(wt_we), .addr(wt_addr), .data(wt_data),
    .weights(weights));

  enc_weight_decoder #(.ENC_BITS(ENC_BITS), .WT_W(WT_W), .ACC_W(ACC_W),
                       .SUM_W(SUM_W)) u_dec (
    .counts(cnt_next), .weights(weights), .sum(dec_sum));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= close_acc;
      if (close_acc) out_sum <= dec_sum;
    end
  end

  // R5: a final beat raises the flag on the next cycle
  assert_flag_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    close_acc |=> out_valid);
  // R5: otherwise the flag is low and the sum holds
  assert_sum_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !close_acc |=> (!out_valid && $stable(out_sum)));
endmodule

// File: tb/sim_enc_column_sum.sv
`timescale 1ns/1ps
module sim_enc_column_sum;
  localparam int NL = 8;
  localparam int EB = 16;
  localparam int MB = 16;
  localparam int NM = NL * EB;
  localparam int AW = 4;
  localparam int SW = 16 + $clog2(NL * MB + 1) + 1 + $clog2(EB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, in_clear = 1'b0;
  logic [NM-1:0] in_vec = '0;
  logic wt_we = 1'b0;
  logic [AW-1:0] wt_addr = '0;
  logic [15:0] wt_data = '0;
  logic out_valid;
  logic [SW-1:0] out_sum;

  always #2.5 clk = ~clk;

  enc_column_sum #(.N_LANES(NL), .ENC_BITS(EB), .MAX_BEATS(MB)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_clear(in_clear), .in_vec(in_vec), .wt_we(wt_we), .wt_addr(wt_addr),
    .wt_data(wt_data), .out_valid(out_valid), .out_sum(out_sum));

  int n_chk = 0;
  int n_fail = 0;
  int w_model [EB];
  longint run_sum = 0;
  longint exp_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected out_valid", 1, 0);
      end else begin
        longint e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(longint'($signed(out_sum)) == e, t, longint'($signed(out_sum)), e);
      end
    end
  end

  task automatic write_wt(input int a, input int d);
    @(negedge clk);
    wt_we = 1'b1; wt_addr = AW'(a); wt_data = 16'(d);
    @(posedge clk); #1;
    wt_we = 1'b0;
    w_model[a] = int'($signed(16'(d)));
  endtask

  task automatic beat(input logic [NM-1:0] v, input bit last, input bit clr, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_vec = v; in_last = last; in_clear = clr;
    if (clr) run_sum = 0;
    for (int i = 0; i < NL; i++)
      for (int j = 0; j < EB; j++)
        if (v[i*EB + j]) run_sum += w_model[j];
    if (last) begin
      exp_q.push_back(run_sum);
      tag_q.push_back(tag);
      run_sum = 0;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; in_clear = 1'b0;
  endtask

  task automatic clear_only();
    @(negedge clk);
    in_clear = 1'b1;
    run_sum = 0;
    @(posedge clk); #1;
    in_clear = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NM-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [SW-1:0] held;
    for (int j = 0; j < EB; j++) w_model[j] = 0;
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(out_sum == '0, "R1 out_sum after reset", longint'(out_sum), 0);
    beat({NM{1'b1}}, 1'b1, 1'b0, "R1 zero weights decode to 0");
    idle(2);

    // R9 load non-power-of-two signed weights
    for (int j = 0; j < EB; j++) write_wt(j, j * 1111 - 7003);

    // R2/R4 single-beat decodes
    beat({{(NM-1){1'b0}}, 1'b1}, 1'b1, 1'b0, "R2 lane0 bit0");
    beat({1'b1, {(NM-1){1'b0}}}, 1'b1, 1'b0, "R2 last lane top bit");
    beat(rnd_vec(), 1'b1, 1'b0, "R4 random single beat");
    beat(rnd_vec(), 1'b1, 1'b0, "R4 random single beat b");

    // R5 flag pulse and hold
    beat(rnd_vec(), 1'b1, 1'b0, "R5 result value");
    @(negedge clk);
    held = out_sum;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5 flag drops", out_valid, 0);
    check(out_sum == held, "R5 sum holds", longint'(out_sum), longint'(held));

    // R8 idle gaps within an accumulation
    beat(rnd_vec(), 1'b0, 1'b0, "R8");
    idle(4);
    beat(rnd_vec(), 1'b0, 1'b0, "R8");
    idle(2);
    beat(rnd_vec(), 1'b1, 1'b0, "R8 idle gaps ignored");

    // R6 back-to-back accumulations
    beat(rnd_vec(), 1'b0, 1'b0, "R6");
    beat(rnd_vec(), 1'b1, 1'b0, "R6 first of pair");
    beat(rnd_vec(), 1'b1, 1'b0, "R6 restart from zero");

    // R7 clear alone and with a beat
    beat({NM{1'b1}}, 1'b0, 1'b0, "R7");
    clear_only();
    beat(rnd_vec(), 1'b1, 1'b0, "R7 lone clear drops counts");
    beat({NM{1'b1}}, 1'b0, 1'b0, "R7");
    beat(rnd_vec(), 1'b1, 1'b1, "R7 clear with beat starts fresh");

    // R9 rewrite one weight, isolate it
    write_wt(5, 1234);
    beat({{(NM-6){1'b0}}, 1'b1, 5'b0}, 1'b1, 1'b0, "R9 weight 5 = 1234");
    write_wt(5, -777);
    beat({{(NM-6){1'b0}}, 1'b1, 5'b0}, 1'b1, 1'b0, "R9 weight 5 rewritten");
    beat({{(NM-7){1'b0}}, 1'b1, 6'b0}, 1'b1, 1'b0, "R9 neighbour weight kept");

    // R3 full-length all-ones runs at extreme weights
    for (int j = 0; j < EB; j++) write_wt(j, -32768);
    for (int b = 0; b < MB; b++)
      beat({NM{1'b1}}, b == MB - 1, 1'b0, "R3 max negative");
    for (int j = 0; j < EB; j++) write_wt(j, 32767);
    for (int b = 0; b < MB; b++)
      beat({NM{1'b1}}, b == MB - 1, 1'b0, "R3 max positive");

    // R4 random accumulations with mixed weights and gaps
    for (int j = 0; j < EB; j++) write_wt(j, int'($urandom_range(65535)) - 32768);
    for (int k = 0; k < 25; k++) begin
      int len;
      len = int'($urandom_range(MB, 1));
      for (int b = 0; b < len; b++) begin
        beat(rnd_vec(), b == len - 1, 1'b0, "R4 random accumulation");
        if ($urandom_range(3) == 0) idle(int'($urandom_range(3, 1)));
      end
    end

    idle(4);
    check(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule